// File: doc/BRIEF.md
# Shift-Based Multiply/Divide Engine

A sequential unsigned arithmetic unit built around three operand registers, X, Y and Z. Each register is `8*SLICES` bits wide, which models a chain of byte-wide slices working as one wide unit. A host loads the operands one register at a time. It then writes a control byte, which picks the operation, can zero Y and/or Z first, and starts a run. The run is paced by an internal shift-pulse generator. That generator fires on every clock cycle, or once every `SLOW_DIV` cycles when the reduced-rate bit is set.

Multiply works by conditional add followed by a right shift. It computes `X*Z + Y` and leaves the double-width result across Y (upper half) and Z (lower half). Divide works by trial subtract followed by a left shift. The dividend is Y:Z and the divisor is X. The quotient goes to Z and the remainder stays in Y, so a further divide can be chained by clearing Z. X is never modified. An active-low overflow flag is refreshed on every control write.

Top module: `mdu_engine`

## Requirements
- R1: After an active-low reset: `busy`, `done` and `rd_valid` are 0, `ovf_n` is 1, and the control byte reads back as 0x00.
- R2: With control op field bits[1:0]=01 (multiply), the result `{Y,Z}` equals `X*Z + Y_start`, with Y holding the upper W bits. Here `Y_start` is Y after any clear.
- R3: With op field 10 (divide) and `Y_start < X`, Z becomes `floor({Y,Z}/X)` and Y becomes `{Y,Z} mod X`.
- R4: X keeps its value through every multiply, divide or overflowed divide.
- R5: On a control write, control bit 3 zeroes Y and control bit 2 zeroes Z before any operation starts; the clears also apply when the op field is 00.
- R6: Every control write sets `ovf_n` to 0 exactly when `Y_start >= X`, which includes X=0. A divide in that condition does not run: Y and Z stay unchanged, `busy` stays 0, and `done` is 1 in the cycle after the write edge.
- R7: With control bit 7 clear, `busy` is high and `done` rises exactly W clock cycles after the control-write edge. With bit 7 set, this takes `SLOW_DIV*W` cycles. Both stay within 8N+1 shift pulses.
- R8: While `busy` is high, register writes have no effect and a read request produces no `rd_valid`.
- R9: `done` is high for exactly one cycle per completed or rejected operation.
- R10: Op codes 00 and 11 start nothing: `busy` and `done` stay 0.
- R11: With `rd_en` asserted while idle, the next cycle shows `rd_valid`=1 and `rdata` holding the addressed register. Addresses are 0=X, 1=Y, 2=Z, 3=control byte, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low clear |
| wr_en | input | 1 | Register write request |
| rd_en | input | 1 | Register read request |
| addr | input | 2 | Register select: 0 X, 1 Y, 2 Z, 3 control |
| wdata | input | W | Write data; control uses bits [7:0] |
| rdata | output | W | Read data, valid with `rd_valid` |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| ovf_n | output | 1 | Overflow flag, low active |

## Verification
The assertions take for granted that the host raises a control write only while idle. A write raised during a run is expected to leave the state alone, not to start anything. They also assume that `wr_en`, `rd_en` and `addr` are stable around the clock edge. The bench drives all inputs on the falling edge. It issues every operation with the control write as the last step of a sequence. It waits for `done` before touching the registers, except in the one deliberate case that probes writes and reads during a run.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_MUL  = 2'b01,
        OP_DIV  = 2'b10,
        OP_RSV  = 2'b11
    } op_e;

    localparam logic [1:0] A_X    = 2'd0;
    localparam logic [1:0] A_Y    = 2'd1;
    localparam logic [1:0] A_Z    = 2'd2;
    localparam logic [1:0] A_CTRL = 2'd3;

    localparam int CB_CLR_Z = 2;
    localparam int CB_CLR_Y = 3;
    localparam int CB_SLOW  = 7;
endpackage

// File: rtl/mdu_pulse_gen.sv
module mdu_pulse_gen #(
    parameter int SLOW_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic slow,
    output logic pulse
);
    localparam int PW = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(SLOW_DIV - 1);

    logic [PW-1:0] pre_d, pre_q;

    always_comb begin
        pre_d = pre_q;
        pulse = 1'b0;
        if (!run) begin
            pre_d = '0;
        end else if (slow) begin
            pulse = (pre_q == PRE_LAST);
            pre_d = pulse ? '0 : pre_q + 1'b1;
        end else begin
            pulse = 1'b1;
            pre_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/mdu_step.sv
module mdu_step #(
    parameter int W = 16
) (
    input  logic         is_div,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] z,
    output logic [W-1:0] y_n,
    output logic [W-1:0] z_n
);
    logic [W:0] sum;
    logic [W:0] part;

    always_comb begin
        sum  = '0;
        part = '0;
        if (is_div) begin
            // shift left one place, then trial subtract
            part = {y, z[W-1]};
            if (part >= {1'b0, x}) begin
                sum = part - {1'b0, x};
                z_n = {z[W-2:0], 1'b1};
            end else begin
                sum = part;
                z_n = {z[W-2:0], 1'b0};
            end
            y_n = sum[W-1:0];
        end else begin
            // conditional add, then shift right across Y:Z
            sum = z[0] ? ({1'b0, y} + {1'b0, x}) : {1'b0, y};
            y_n = sum[W:1];
            z_n = {sum[0], z[W-1:1]};
        end
    end
endmodule

// File: rtl/mdu_engine.sv
module mdu_engine
    import mdu_pkg::*;
#(
    parameter int SLICES   = 2,
    parameter int SLOW_DIV = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [1:0]            addr,
    input  logic [8*SLICES-1:0]   wdata,
    output logic [8*SLICES-1:0]   rdata,
    output logic                  rd_valid,
    output logic                  busy,
    output logic                  done,
    output logic                  ovf_n
);
    localparam int W  = 8 * SLICES;
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] STEP_LAST = CW'(W - 1);

    typedef struct packed {
        logic [W-1:0]  x;
        logic [W-1:0]  y;
        logic [W-1:0]  z;
        logic [7:0]    ctrl;
        op_e           op;
        logic          busy;
        logic          done;
        logic          ovf_n;
        logic [CW-1:0] cnt;
        logic [W-1:0]  rdata;
        logic          rd_valid;
    } state_t;

    state_t s_d, s_q;

    logic         pulse;
    logic [W-1:0] step_y, step_z;
    logic [W-1:0] y_start, z_start;
    logic [W-1:0] x_cur;

    mdu_pulse_gen #(.SLOW_DIV(SLOW_DIV)) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (s_q.busy),
        .slow  (s_q.ctrl[CB_SLOW]),
        .pulse (pulse)
    );

    mdu_step #(.W(W)) u_step (
        .is_div (s_q.op == OP_DIV),
        .x      (s_q.x),
        .y      (s_q.y),
        .z      (s_q.z),
        .y_n    (step_y),
        .z_n    (step_z)
    );

    always_comb begin
        s_d          = s_q;
        s_d.done     = 1'b0;
        s_d.rd_valid = 1'b0;
        y_start      = wdata[CB_CLR_Y] ? '0 : s_q.y;
        z_start      = wdata[CB_CLR_Z] ? '0 : s_q.z;

        if (!s_q.busy) begin
            if (rd_en) begin
                s_d.rd_valid = 1'b1;
                case (addr)
                    A_X:     s_d.rdata = s_q.x;
                    A_Y:     s_d.rdata = s_q.y;
                    A_Z:     s_d.rdata = s_q.z;
                    default: s_d.rdata = {{(W-8){1'b0}}, s_q.ctrl};
                endcase
            end
            if (wr_en) begin
                case (addr)
                    A_X: s_d.x = wdata;
                    A_Y: s_d.y = wdata;
                    A_Z: s_d.z = wdata;
                    default: begin
                        s_d.ctrl  = wdata[7:0];
                        s_d.op    = op_e'(wdata[1:0]);
                        s_d.y     = y_start;
                        s_d.z     = z_start;
                        s_d.ovf_n = !(y_start >= s_q.x);
                        s_d.cnt   = '0;
                        case (op_e'(wdata[1:0]))
                            OP_MUL: s_d.busy = 1'b1;
                            OP_DIV: begin
                                if (y_start >= s_q.x) s_d.done = 1'b1;
                                else                  s_d.busy = 1'b1;
                            end
                            default: ;
                        endcase
                    end
                endcase
            end
        end else if (pulse) begin
            s_d.y   = step_y;
            s_d.z   = step_z;
            s_d.cnt = s_q.cnt + 1'b1;
            if (s_q.cnt == STEP_LAST) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
                s_d.cnt  = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.ovf_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata    = s_q.rdata;
    assign rd_valid = s_q.rd_valid;
    assign busy     = s_q.busy;
    assign done     = s_q.done;
    assign ovf_n    = s_q.ovf_n;
    assign x_cur    = s_q.x;
endmodule

// File: rtl/mdu_engine_chk.sv
module mdu_engine_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic [1:0]   addr,
    input logic         rd_valid,
    input logic         busy,
    input logic         done,
    input logic         ovf_n,
    input logic [W-1:0] x_cur
);
    assert_done_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_idle_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_run_ends_in_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> (busy || done));

    assert_x_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(x_cur));

    assert_no_read_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !$past(busy));

    assert_start_by_ctrl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_en && addr == 2'd3));

    assert_ovf_on_ctrl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ovf_n) |-> $past(wr_en && addr == 2'd3 && !busy));
endmodule

bind mdu_engine mdu_engine_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .rd_valid (rd_valid),
    .busy     (busy),
    .done     (done),
    .ovf_n    (ovf_n),
    .x_cur    (x_cur)
);

// File: tb/test_mdu_engine.sv
`timescale 1ns/1ps
module test_mdu_engine;
    localparam int W    = 16;
    localparam int SDIV = 4;
    localparam int NV   = 9;

    localparam logic [1:0]   V_OP [NV] = '{2'b01, 2'b01, 2'b01, 2'b01, 2'b10, 2'b10, 2'b10, 2'b10, 2'b10};
    localparam logic [W-1:0] V_X  [NV] = '{16'h0003, 16'hFFFF, 16'h0000, 16'h1234, 16'h0007, 16'h0007, 16'hFFFF, 16'h0005, 16'h0000};
    localparam logic [W-1:0] V_Y  [NV] = '{16'h0000, 16'hFFFF, 16'h0007, 16'h0000, 16'h0000, 16'h0006, 16'hFFFE, 16'h0005, 16'h0003};
    localparam logic [W-1:0] V_Z  [NV] = '{16'h0005, 16'hFFFF, 16'h1234, 16'h0100, 16'h0064, 16'h0000, 16'hFFFF, 16'h0042, 16'h0099};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [1:0]   addr = 2'd0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic         rd_valid, busy, done, ovf_n;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    mdu_engine #(.SLICES(2), .SLOW_DIV(SDIV)) i_mdu_engine (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .busy(busy),
        .done(done), .ovf_n(ovf_n)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [W-1:0] d, output logic v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata; v = rd_valid;
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (!done && n < 100000) begin
            @(posedge clk);
            @(negedge clk);
            n++;
        end
    endtask

    task automatic rd_chk(input logic [1:0] a, input string req, input longint exp);
        logic [W-1:0] d;
        logic v;
        rd(a, d, v);
        check({req, " rd_valid"}, v, 1);
        check(req, d, exp);
    endtask

    initial begin
        #4000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int n;
        logic [W-1:0] d;
        logic v;
        longint dvd, ex_y, ex_z;
        logic [W-1:0] rem;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 ovf_n", ovf_n, 1);
        check("R1 rd_valid", rd_valid, 0);
        rst_n = 1'b1;
        rd_chk(2'd3, "R1 ctrl", 0);

        // Vector table: R2, R3, R4, R6, R7, R9
        for (int i = 0; i < NV; i++) begin
            wr(2'd0, V_X[i]);
            wr(2'd1, V_Y[i]);
            wr(2'd2, V_Z[i]);
            wr(2'd3, {14'd0, V_OP[i]});
            wait_done(n);
            if (V_OP[i] == 2'b01) begin
                dvd  = longint'(V_X[i]) * longint'(V_Z[i]) + longint'(V_Y[i]);
                ex_y = dvd >> W;
                ex_z = dvd & 64'hFFFF;
                check("R7 mul cycles", n, W);
            end else if (V_Y[i] >= V_X[i]) begin
                ex_y = V_Y[i];
                ex_z = V_Z[i];
                check("R6 ovf_n low", ovf_n, 0);
                check("R6 done at write", n, 0);
                check("R6 no run", busy, 0);
            end else begin
                dvd  = (longint'(V_Y[i]) << W) | longint'(V_Z[i]);
                ex_z = dvd / longint'(V_X[i]);
                ex_y = dvd % longint'(V_X[i]);
                check("R6 ovf_n high", ovf_n, 1);
                check("R7 div cycles", n, W);
            end
            @(negedge clk);
            check("R9 done drops", done, 0);
            rd_chk(2'd1, (V_OP[i] == 2'b01) ? "R2 Y" : "R3 Y", ex_y);
            rd_chk(2'd2, (V_OP[i] == 2'b01) ? "R2 Z" : "R3 Z", ex_z);
            rd_chk(2'd0, "R4 X", V_X[i]);
        end

        // R3 chained divide: 1000/7 then divide remainder again with Z cleared
        wr(2'd0, 16'd7); wr(2'd1, 16'd0); wr(2'd2, 16'd1000);
        wr(2'd3, 16'h0002);
        wait_done(n);
        rem = 16'(1000 % 7);
        wr(2'd3, 16'h0006);
        wait_done(n);
        dvd = longint'(rem) << W;
        rd_chk(2'd2, "R3 chain Z", dvd / 7);
        rd_chk(2'd1, "R3 chain Y", dvd % 7);

        // R5: clears with op 00, and Y clear before multiply
        wr(2'd1, 16'h1111); wr(2'd2, 16'h2222);
        wr(2'd3, 16'h0004);
        rd_chk(2'd2, "R5 Z cleared", 0);
        rd_chk(2'd1, "R5 Y kept", 16'h1111);
        wr(2'd3, 16'h0008);
        rd_chk(2'd1, "R5 Y cleared", 0);
        wr(2'd0, 16'd10); wr(2'd1, 16'h5555); wr(2'd2, 16'd9);
        wr(2'd3, 16'h0009);
        wait_done(n);
        rd_chk(2'd1, "R5 mul Y", 0);
        rd_chk(2'd2, "R5 mul Z", 90);

        // R10: op 00 and 11 start nothing
        wr(2'd3, 16'h0003);
        check("R10 rsv busy", busy, 0);
        check("R10 rsv done", done, 0);
        repeat (3) @(negedge clk);
        check("R10 rsv later", busy | done, 0);
        wr(2'd3, 16'h0000);
        check("R10 none busy", busy | done, 0);

        // R7 slow rate and R11 control readback
        wr(2'd0, 16'd3); wr(2'd1, 16'd0); wr(2'd2, 16'd4);
        wr(2'd3, 16'h0081);
        wait_done(n);
        check("R7 slow cycles", n, SDIV * W);
        rd_chk(2'd2, "R7 slow result", 12);
        rd_chk(2'd3, "R11 ctrl readback", 16'h0081);

        // R8: write and read during a run are ignored
        wr(2'd0, 16'd6); wr(2'd1, 16'd0); wr(2'd2, 16'd7);
        wr(2'd3, 16'h0001);
        check("R8 busy", busy, 1);
        wr(2'd0, 16'hAAAA);
        rd(2'd0, d, v);
        check("R8 no rd_valid", v, 0);
        wait_done(n);
        rd_chk(2'd0, "R8 X unchanged", 6);
        rd_chk(2'd2, "R8 result", 42);

        // R1: reset in the middle of a run
        wr(2'd3, 16'h0001);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run busy", busy, 0);
        check("R1 mid-run ovf_n", ovf_n, 1);
        rst_n = 1'b1;
        rd_chk(2'd3, "R1 ctrl after reset", 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule